// File: doc/BRIEF.md
# Channel Clock Divider with Coarse Phase Offset

This block divides a fast input clock by a programmable ratio. It produces a registered output level that a clock-enable network or an output stage can use. The time high and the time low are set separately, as whole input cycles. This allows asymmetric duty cycles as well as the usual square wave. Several copies of the block run from the same input clock. Each copy can be given its own coarse delay, so that its outputs are skewed against one another in steps of one input cycle.

The delay is built from a 4-bit offset field and a late-start flag. With the flag clear, the delay equals the offset field. With the flag set, the delay equals the offset field plus the programmed low time plus one. A new delay is captured only while the synchronisation request is high. The synchronisation request is level-sensitive. While it is high the output is forced low and all counting stops. The first input clock edge that sees it low starts the delay count. Changes to the high or low fields during normal running are picked up only when the next high phase begins.

Top module: `chdiv_phase`

## Requirements
- R1: After the delay, the output is high for hi_cnt+1 input cycles and then low for lo_cnt+1 input cycles. Both fields hold the cycle count minus one.
- R2: Every full output period lasts hi_cnt+lo_cnt+2 input cycles.
- R3: With ph_late = 0, the delay is ph_ofs cycles. The first rising edge follows the (ph_ofs+1)-th clock edge that samples sync_req low.
- R4: With ph_late = 1, the delay is ph_ofs + L + 1 cycles, where L is the lo_cnt value sampled while sync_req was high.
- R5: Changes to ph_ofs or ph_late while sync_req is low have no effect on the output.
- R6: Every clock edge that samples sync_req high drives the output low and restarts the delay sequence. The sequence runs again once sync_req is released.
- R7: A change of hi_cnt or lo_cnt does not cut the current period short. The values sampled at the edge that starts a high phase govern that whole period.
- R8: Two instances synchronised together show a skew between their first rising edges that equals the difference of their delays, in input cycles.
- R9: While rst_n is low, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Level synchronisation request; captures the offset and holds the output low |
| hi_cnt | input | CNT_W | High time minus one, in input cycles |
| lo_cnt | input | CNT_W | Low time minus one, in input cycles |
| ph_ofs | input | PO_W | Coarse offset field, in input cycles |
| ph_late | input | 1 | Late-start flag; adds lo_cnt+1 to the delay |
| clk_div_out | output | 1 | Registered divided clock level |

## Verification
The hardest case to reach is a running divider that receives new high, low and offset values in the same cycle, in the middle of a period, with no synchronisation. In that case the old period must finish unchanged, the new ratio must start at the next rising edge, and the phase must not move. The stimulus reaches this case by changing all fields at a chosen cycle inside a running segment. The expected waveform for each instance is computed edge by edge from the rise times the requirements define. Two instances with one delay from each formula are synchronised together, and the skew between their first edges is compared as well.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } wave_st_t;

  // Coarse delay in input cycles: early case uses the offset alone,
  // late case adds the low time (count+1) on top of the offset.
  function automatic int unsigned phase_delay(input bit late,
                                              input int unsigned ofs,
                                              input int unsigned lo_field);
    int unsigned d;
    if (late) d = ofs + lo_field + 1;
    else      d = ofs;
    return d;
  endfunction

endpackage

// File: rtl/chdiv_offset_cap.sv
module chdiv_offset_cap
  import chdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PO_W  = 4,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic             late_in,
  input  logic [PO_W-1:0]  ofs_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic [DLY_W-1:0] dly
);

  logic             late_q;
  logic [PO_W-1:0]  ofs_q;
  logic [CNT_W-1:0] lo_q;

  // Offset fields are only sampled while a sync is requested.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_q <= 1'b0;
      ofs_q  <= '0;
      lo_q   <= '0;
    end else if (sync_req) begin
      late_q <= late_in;
      ofs_q  <= ofs_in;
      lo_q   <= lo_in;
    end
  end

  always_comb begin
    dly = DLY_W'(phase_delay(late_q, int'(ofs_q), int'(lo_q)));
  end

  // R5: without a sync the applied delay must not move
  p_offset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |=> $stable(dly));

endmodule

// File: rtl/chdiv_wave.sv
module chdiv_wave
  import chdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [DLY_W-1:0] dly,
  output logic             wave_out,
  output logic             period_start
);

  wave_st_t         state;
  logic [DLY_W-1:0] cnt;
  logic [CNT_W-1:0] lo_act;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  // Named event: the next edge begins a high phase (period boundary).
  always_comb begin
    period_start = 1'b0;
    if (!sync_req) begin
      unique case (state)
        ST_HOLD:  period_start = (dly == '0);
        ST_DELAY: period_start = cnt_zero;
        ST_LOW:   period_start = cnt_zero;
        default:  period_start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HOLD;
      cnt      <= '0;
      lo_act   <= '0;
      wave_out <= 1'b0;
    end else if (sync_req) begin
      state    <= ST_HOLD;
      cnt      <= '0;
      wave_out <= 1'b0;
    end else if (period_start) begin
      state    <= ST_HIGH;
      cnt      <= DLY_W'(hi_in);
      lo_act   <= lo_in;
      wave_out <= 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          state <= ST_DELAY;
          cnt   <= dly - 1'b1;
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            state    <= ST_LOW;
            cnt      <= DLY_W'(lo_act);
            wave_out <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R6: a sampled sync always forces the output low
  p_sync_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !wave_out);

  // R1: high phase is not cut short before its count expires
  p_high_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_out && state == ST_HIGH && !cnt_zero && !sync_req) |=> wave_out);

  // R1: low phase is not cut short before its count expires
  p_low_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW && !cnt_zero && !sync_req) |=> !wave_out);

  // R7: the applied low time only changes at a period boundary
  p_lo_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(lo_act));

  // R7: every rising edge coincides with a period boundary
  p_rise_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_out) |-> $past(period_start));

endmodule

// File: rtl/chdiv_phase.sv
module chdiv_phase
  import chdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PO_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [PO_W-1:0]  ph_ofs,
  input  logic             ph_late,
  output logic             clk_div_out
);

  localparam int MAX_W = (CNT_W > PO_W) ? CNT_W : PO_W;
  localparam int DLY_W = MAX_W + 1;

  logic [DLY_W-1:0] dly;
  logic             period_start;

  chdiv_offset_cap #(
    .CNT_W(CNT_W),
    .PO_W (PO_W),
    .DLY_W(DLY_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_req(sync_req),
    .late_in (ph_late),
    .ofs_in  (ph_ofs),
    .lo_in   (lo_cnt),
    .dly     (dly)
  );

  chdiv_wave #(
    .CNT_W(CNT_W),
    .DLY_W(DLY_W)
  ) u_wave (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_req    (sync_req),
    .hi_in       (hi_cnt),
    .lo_in       (lo_cnt),
    .dly         (dly),
    .wave_out    (clk_div_out),
    .period_start(period_start)
  );

  // R9: output is low whenever reset is applied
  always_comb begin
    if (!rst_n) p_reset_low_r9: assert (!clk_div_out || $time == 0);
  end

endmodule

// File: tb/chdiv_phase_test.sv
`timescale 1ns/1ps
module chdiv_phase_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_req = 1'b1;
  logic [3:0] hi_cnt = 4'd0;
  logic [3:0] lo_cnt = 4'd0;
  logic [3:0] a_ofs = 4'd0, b_ofs = 4'd0;
  logic       a_late = 1'b0, b_late = 1'b0;
  logic       out_a, out_b;

  always #5 clk = ~clk;

  chdiv_phase uut (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .ph_ofs(a_ofs), .ph_late(a_late),
    .clk_div_out(out_a)
  );

  chdiv_phase uut_b (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .ph_ofs(b_ofs), .ph_late(b_late),
    .clk_div_out(out_b)
  );

  typedef struct {
    bit    a;
    bit    b;
    int    idx;
    string tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0, n_fail = 0;
  int    first_a = -1, first_b = -1;
  bit    prev_a = 0, prev_b = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per cycle, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(out_a == it.a, {it.tag, " inst A"}, out_a, it.a);
        check(out_b == it.b, {it.tag, " inst B"}, out_b, it.b);
        if (it.idx > 0 && out_a && !prev_a && first_a < 0) first_a = it.idx;
        if (it.idx > 0 && out_b && !prev_b && first_b < 0) first_b = it.idx;
        prev_a = out_a;
        prev_b = out_b;
      end
    end
  end

  task automatic step(input bit ea, input bit eb, input int idx, input string tag);
    item_t it;
    @(posedge clk);
    it.a = ea; it.b = eb; it.idx = idx; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  function automatic int dly_of(input bit late, input int ofs, input int lo);
    return late ? (ofs + lo + 1) : ofs;
  endfunction

  // Driver: one sync, then a run; fields switch to n1/m1 at edge sw.
  task automatic run_seg(input int n0, input int m0, input int n1, input int m1,
                         input int sw, input bit la, input int oa,
                         input bit lb, input int ob, input int len, input bit poke);
    int da, db;
    int rise_a, hiend_a, next_a, rise_b, hiend_b, next_b;
    string tg;
    sync_req = 1'b1;
    hi_cnt = 4'(n0); lo_cnt = 4'(m0);
    a_late = la; a_ofs = 4'(oa); b_late = lb; b_ofs = 4'(ob);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, "R6 sync hold");
    da = dly_of(la, oa, m0);
    db = dly_of(lb, ob, m0);
    first_a = -1; first_b = -1;
    rise_a = -1; hiend_a = -1; next_a = da + 1;
    rise_b = -1; hiend_b = -1; next_b = db + 1;
    sync_req = 1'b0;
    for (int i = 1; i <= len; i++) begin
      bit ea, eb;
      if (i == sw) begin
        hi_cnt = 4'(n1); lo_cnt = 4'(m1);
        if (poke) begin
          a_ofs = ~a_ofs; a_late = ~a_late;
          b_ofs = b_ofs + 4'd5; b_late = ~b_late;
        end
      end
      if (i == next_a) begin
        rise_a = i;
        hiend_a = i + ((i >= sw) ? n1 : n0);
        next_a = hiend_a + ((i >= sw) ? m1 : m0) + 2;
      end
      if (i == next_b) begin
        rise_b = i;
        hiend_b = i + ((i >= sw) ? n1 : n0);
        next_b = hiend_b + ((i >= sw) ? m1 : m0) + 2;
      end
      ea = (rise_a > 0 && i <= hiend_a);
      eb = (rise_b > 0 && i <= hiend_b);
      if (i == da + 1 || i == db + 1) tg = (la || lb) ? "R4 late delay" : "R3 early delay";
      else if (poke && i >= sw)       tg = "R5/R7 change without sync";
      else if (i >= sw)               tg = "R7 field change";
      else if (i > da + n0 + m0 + 3)  tg = "R2 period";
      else                            tg = "R1 high/low";
      step(ea, eb, i, tg);
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    // R8: skew between first rising edges equals the delay difference
    check((first_b - first_a) == (db - da), "R8 skew", first_b - first_a, db - da);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(out_a == 1'b0 && out_b == 1'b0, "R9 reset low", out_a + out_b, 0);
    end
    rst_n = 1'b1;
    // early delays only
    run_seg(2, 3, 2, 3, 1000, 1'b0, 0, 1'b0, 5, 60, 1'b0);
    // one late, one early
    run_seg(1, 4, 1, 4, 1000, 1'b1, 2, 1'b0, 3, 60, 1'b0);
    // mid-run field change plus offset poke without sync
    run_seg(3, 2, 0, 5, 25, 1'b0, 7, 1'b1, 0, 70, 1'b1);
    // extreme fields: largest late delay
    run_seg(15, 15, 15, 15, 1000, 1'b1, 15, 1'b0, 15, 100, 1'b0);
    // divide by two
    run_seg(0, 0, 0, 0, 1000, 1'b0, 1, 1'b0, 0, 20, 1'b0);
    // change of high field only, late on both
    run_seg(0, 2, 4, 2, 12, 1'b1, 1, 1'b1, 3, 50, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule